// File: doc/BRIEF.md
# Shared-RAM Host Access Handshake Controller

This block is the synchronous slave port through which a host processor reads and writes a 16-bit shared memory or register file. An internal protocol engine also uses that storage and has first claim on it. The host asks for a transfer by holding both its strobe and its select low. When the engine is not asking for the storage, the block opens a transfer by driving its active-low transfer-enable output low. It then captures the memory/register qualifier and the read/write qualifier on the next falling clock edge, and captures the address and the write data on the next rising edge. After a fixed count of rising edges it issues a single-cycle access to the storage and drives its active-low ready output low.

The count is three rising edges for writes and for register reads, and seven for memory reads. The host ends the cycle by raising its strobe. A separate address-latch control lets a multiplexed address/data bus share the address pins: the block keeps the last address seen while that control was high.

Top module: `hhp_host_port`

## Requirements
- R1: A host request exists only at a rising edge where `strobe_n` and `select_n` are both low. With `select_n` high, `xfer_en_n` stays high (1 = idle).
- R2: The engine has priority. While `eng_req` is high the block starts no transfer and `eng_gnt` is high. A pending host request starts on the first rising edge at which `eng_req` is low, and `xfer_en_n` goes low after that edge.
- R3: While `xfer_en_n` is low, `eng_gnt` stays low even when `eng_req` is high.
- R4: `space_mem` (1 = memory, 0 = register) and `dir_rd` (1 = read, 0 = write) are captured on the first falling edge after the transfer starts. Later changes to them have no effect on that transfer.
- R5: The transfer address and the write data are captured on the first rising edge after `xfer_en_n` goes low. Later changes to `addr_in` or `wdata_in` have no effect on that transfer.
- R6: `ready_n` goes low on rising edge 7 after `xfer_en_n` goes low for a memory read (`space_mem`=1, `dir_rd`=1). It goes low on rising edge 3 for every other access.
- R7: The storage sees exactly one cycle with `mem_cs` high, ending at the edge where `ready_n` goes low. In that cycle `mem_we`, `mem_is_mem`, `mem_addr` and `mem_wdata` carry the captured access. For a read, `rdata_out` then holds the value `mem_rdata` had in that cycle.
- R8: `rdata_oe` is high, and `rdata_out` carries data, only while `ready_n` is low in a read cycle. At all other times `rdata_out` is zero.
- R9: At a rising edge where `ready_n` is low and `strobe_n` is high, the block returns to idle. After that edge `ready_n` and `xfer_en_n` are both high.
- R10: While `strobe_n` stays low after ready, `ready_n` and `xfer_en_n` stay low and no new transfer begins.
- R11: While `addr_lat` is high, the address captured for a transfer is `addr_in`. While it is low, the captured address is the `addr_in` value sampled at the last rising edge at which `addr_lat` was high.
- R12: During and right after reset, `xfer_en_n` and `ready_n` are high, `mem_cs` is low and `rdata_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_n | input | 1 | Host strobe, active low |
| select_n | input | 1 | Host select, active low |
| space_mem | input | 1 | 1 = memory access, 0 = register access |
| dir_rd | input | 1 | 1 = read, 0 = write |
| addr_lat | input | 1 | Address follow (high) / hold (low) control |
| addr_in | input | AW | Host address pins |
| wdata_in | input | DW | Host write data |
| rdata_out | output | DW | Read data to host, zero when not enabled |
| rdata_oe | output | 1 | Read data valid / drive enable |
| xfer_en_n | output | 1 | Transfer in progress, active low |
| ready_n | output | 1 | Access complete, active low |
| eng_req | input | 1 | Protocol engine wants the storage |
| eng_gnt | output | 1 | Protocol engine may use the storage |
| mem_cs | output | 1 | Storage access strobe |
| mem_we | output | 1 | Storage write enable |
| mem_is_mem | output | 1 | 1 = memory array, 0 = register file |
| mem_addr | output | AW | Storage address |
| mem_wdata | output | DW | Storage write data |
| mem_rdata | input | DW | Storage read data |

## Verification
The bench scrambles the qualifiers, the address and the write data one cycle after a transfer opens. A design that sampled them late would write the wrong location, run the wrong wait count or turn a write into a read. It times every ready pulse against the start of its transfer, so a counter off by one, or one that ignores the memory-read case, shows up as a wrong edge count. It holds the engine request high over a pending host request and raises it again during a transfer: a block that starts early or hands the storage to the engine mid-transfer is caught. It also keeps the strobe low after ready to catch a block that restarts, and it reads through a held address latch to catch one that keeps following the pins.

// File: rtl/hhp_pkg.sv
package hhp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } hhp_state_e;

  typedef struct packed {
    logic is_mem;
    logic is_rd;
  } hhp_qual_t;

endpackage

// File: rtl/hhp_req_arb.sv
module hhp_req_arb (
  input  logic strobe_n,
  input  logic select_n,
  input  logic eng_req,
  input  logic host_idle,
  output logic host_start,
  output logic eng_gnt
);

  logic host_req;

  always_comb begin
    host_req   = !strobe_n && !select_n;
    // Engine wins a same-cycle tie; host holds storage once started.
    host_start = host_idle && host_req && !eng_req;
    eng_gnt    = host_idle && eng_req;
  end

endmodule

// File: rtl/hhp_seq.sv
module hhp_seq
  import hhp_pkg::*;
#(
  parameter int MEM_RD_LAT = 7,
  parameter int SHORT_LAT  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_start,
  input  logic       strobe_n,
  input  hhp_qual_t  qual,
  output hhp_state_e state,
  output logic       first_cyc,
  output logic       fire
);

  localparam int MAXL = (MEM_RD_LAT > SHORT_LAT) ? MEM_RD_LAT : SHORT_LAT;
  localparam int CW   = (MAXL > 2) ? $clog2(MAXL) : 1;
  localparam logic [CW-1:0] LONG_LAST  = CW'(MEM_RD_LAT - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_LAT - 1);

  hhp_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last_cnt;

  always_comb begin
    last_cnt = (qual.is_mem && qual.is_rd) ? LONG_LAST : SHORT_LAST;
    state_d  = state_q;
    cnt_d    = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (host_start) begin
          state_d = ST_XFER;
          cnt_d   = '0;
        end
      end
      ST_XFER: begin
        if (cnt_q == last_cnt) begin
          state_d = ST_DONE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DONE: begin
        if (strobe_n) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    state     = state_q;
    first_cyc = (state_q == ST_XFER) && (cnt_q == '0);
    fire      = (state_q == ST_XFER) && (cnt_q == last_cnt);
  end

endmodule

// File: rtl/hhp_addr_latch.sv
module hhp_addr_latch #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_lat,
  input  logic [AW-1:0] addr_in,
  input  logic          cap_en,
  output logic [AW-1:0] xfer_addr
);

  logic [AW-1:0] hold_q;
  logic [AW-1:0] eff_addr;
  logic [AW-1:0] xfer_q;

  always_comb begin
    eff_addr = addr_lat ? addr_in : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (addr_lat) begin
      hold_q <= addr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_q <= '0;
    end else if (cap_en) begin
      xfer_q <= eff_addr;
    end
  end

  assign xfer_addr = xfer_q;

endmodule

// File: rtl/hhp_datapath.sv
module hhp_datapath
  import hhp_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          first_cyc,
  input  logic          fire,
  input  logic          done,
  input  logic          space_mem,
  input  logic          dir_rd,
  input  logic [DW-1:0] wdata_in,
  input  logic [AW-1:0] xfer_addr,
  input  logic [DW-1:0] mem_rdata,
  output hhp_qual_t     qual,
  output logic          mem_cs,
  output logic          mem_we,
  output logic          mem_is_mem,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] rdata_out,
  output logic          rdata_oe
);

  hhp_qual_t     qual_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          rd_cap_en;

  // Qualifiers: first falling edge of the transfer.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_q <= '0;
    end else if (first_cyc) begin
      qual_q <= '{is_mem: space_mem, is_rd: dir_rd};
    end
  end

  // Write data: same rising edge as the address.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
    end else if (first_cyc) begin
      wdata_q <= wdata_in;
    end
  end

  always_comb begin
    rd_cap_en = fire && qual_q.is_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_cap_en) begin
      rdata_q <= mem_rdata;
    end
  end

  always_comb begin
    qual       = qual_q;
    mem_cs     = fire;
    mem_we     = fire && !qual_q.is_rd;
    mem_is_mem = qual_q.is_mem;
    mem_addr   = xfer_addr;
    mem_wdata  = wdata_q;
    rdata_oe   = done && qual_q.is_rd;
    rdata_out  = rdata_oe ? rdata_q : '0;
  end

endmodule

// File: rtl/hhp_host_port.sv
module hhp_host_port
  import hhp_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 16,
  parameter int MEM_RD_LAT  = 7,
  parameter int SHORT_LAT   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_n,
  input  logic          select_n,
  input  logic          space_mem,
  input  logic          dir_rd,
  input  logic          addr_lat,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  output logic [DW-1:0] rdata_out,
  output logic          rdata_oe,
  output logic          xfer_en_n,
  output logic          ready_n,
  input  logic          eng_req,
  output logic          eng_gnt,
  output logic          mem_cs,
  output logic          mem_we,
  output logic          mem_is_mem,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  hhp_state_e    state;
  hhp_qual_t     qual_q;
  logic          host_start;
  logic          host_idle;
  logic          first_cyc;
  logic          fire;
  logic          done;
  logic [AW-1:0] xfer_addr;

  always_comb begin
    host_idle = (state == ST_IDLE);
    done      = (state == ST_DONE);
    xfer_en_n = host_idle;
    ready_n   = !done;
  end

  hhp_req_arb u_arb (
    .strobe_n  (strobe_n),
    .select_n  (select_n),
    .eng_req   (eng_req),
    .host_idle (host_idle),
    .host_start(host_start),
    .eng_gnt   (eng_gnt)
  );

  hhp_seq #(
    .MEM_RD_LAT(MEM_RD_LAT),
    .SHORT_LAT (SHORT_LAT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .host_start(host_start),
    .strobe_n  (strobe_n),
    .qual      (qual_q),
    .state     (state),
    .first_cyc (first_cyc),
    .fire      (fire)
  );

  hhp_addr_latch #(
    .AW(AW)
  ) u_alat (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .addr_lat (addr_lat),
    .addr_in  (addr_in),
    .cap_en   (first_cyc),
    .xfer_addr(xfer_addr)
  );

  hhp_datapath #(
    .AW(AW),
    .DW(DW)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .first_cyc (first_cyc),
    .fire      (fire),
    .done      (done),
    .space_mem (space_mem),
    .dir_rd    (dir_rd),
    .wdata_in  (wdata_in),
    .xfer_addr (xfer_addr),
    .mem_rdata (mem_rdata),
    .qual      (qual_q),
    .mem_cs    (mem_cs),
    .mem_we    (mem_we),
    .mem_is_mem(mem_is_mem),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .rdata_out (rdata_out),
    .rdata_oe  (rdata_oe)
  );

endmodule

// File: rtl/hhp_chk.sv
module hhp_chk #(
  parameter int AW         = 16,
  parameter int MEM_RD_LAT = 7,
  parameter int SHORT_LAT  = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          strobe_n,
  input logic          select_n,
  input logic          eng_req,
  input logic          eng_gnt,
  input logic          xfer_en_n,
  input logic          ready_n,
  input logic          rdata_oe,
  input logic          mem_cs,
  input logic [AW-1:0] mem_addr,
  input logic          q_is_mem,
  input logic          q_is_rd
);

  // Edge counter since the transfer opened; saturates.
  logic [3:0] xcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xcnt_q <= '0;
    end else if (xfer_en_n) begin
      xcnt_q <= '0;
    end else if (xcnt_q != 4'hF) begin
      xcnt_q <= xcnt_q + 1'b1;
    end
  end

  p_start_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_en_n) |-> $past(!strobe_n && !select_n));

  p_engine_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_en_n) |-> $past(!eng_req));

  p_engine_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_en_n |-> !eng_gnt);

  p_qual_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_en_n && $past(!xfer_en_n)) |-> ($stable(q_is_mem) && $stable(q_is_rd)));

  p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_en_n && $past(!xfer_en_n) && $past(!xfer_en_n, 2)) |-> $stable(mem_addr));

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_n) |->
      (32'(xcnt_q) == ((q_is_mem && q_is_rd) ? MEM_RD_LAT : SHORT_LAT)));

  p_cs_before_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs |=> $fell(ready_n));

  p_cs_inside_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs |-> (!xfer_en_n && ready_n));

  p_oe_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (!ready_n && q_is_rd));

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_n && strobe_n) |=> (ready_n && xfer_en_n));

  p_ready_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_n && !strobe_n) |=> (!ready_n && !xfer_en_n));

endmodule

bind hhp_host_port hhp_chk #(
  .AW        (AW),
  .MEM_RD_LAT(MEM_RD_LAT),
  .SHORT_LAT (SHORT_LAT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .strobe_n (strobe_n),
  .select_n (select_n),
  .eng_req  (eng_req),
  .eng_gnt  (eng_gnt),
  .xfer_en_n(xfer_en_n),
  .ready_n  (ready_n),
  .rdata_oe (rdata_oe),
  .mem_cs   (mem_cs),
  .mem_addr (mem_addr),
  .q_is_mem (qual_q.is_mem),
  .q_is_rd  (qual_q.is_rd)
);

// File: tb/hhp_host_port_tb.sv
module hhp_host_port_tb;

  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk;
  logic          rst_n;
  logic          strobe_n, select_n, space_mem, dir_rd, addr_lat;
  logic [AW-1:0] addr_in;
  logic [DW-1:0] wdata_in;
  logic [DW-1:0] rdata_out;
  logic          rdata_oe, xfer_en_n, ready_n;
  logic          eng_req, eng_gnt;
  logic          mem_cs, mem_we, mem_is_mem;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  hhp_host_port u_dut (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .select_n(select_n),
    .space_mem(space_mem), .dir_rd(dir_rd), .addr_lat(addr_lat),
    .addr_in(addr_in), .wdata_in(wdata_in), .rdata_out(rdata_out),
    .rdata_oe(rdata_oe), .xfer_en_n(xfer_en_n), .ready_n(ready_n),
    .eng_req(eng_req), .eng_gnt(eng_gnt), .mem_cs(mem_cs), .mem_we(mem_we),
    .mem_is_mem(mem_is_mem), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Storage model and the bench's own record of expected contents.
  logic [DW-1:0] mem_arr [16];
  logic [DW-1:0] reg_arr [16];
  logic [DW-1:0] exp_mem [16];
  logic [DW-1:0] exp_reg [16];

  assign mem_rdata = mem_is_mem ? mem_arr[mem_addr[3:0]] : reg_arr[mem_addr[3:0]];

  always @(posedge clk) begin
    if (mem_cs && mem_we) begin
      if (mem_is_mem) mem_arr[mem_addr[3:0]] <= mem_wdata;
      else            reg_arr[mem_addr[3:0]] <= mem_wdata;
    end
  end

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  typedef struct packed {
    logic          is_rd;
    logic          is_mem;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [3:0]    lat;
  } sb_item_t;

  sb_item_t sbq[$];

  // Monitor: times each ready pulse and compares against the queue.
  int            ecnt = 0;
  logic          prev_x = 1'b1, prev_r = 1'b1;
  logic [AW-1:0] cs_addr = '0;
  logic          cs_mem = 1'b0, cs_we = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!xfer_en_n && prev_x) ecnt = 0;
      else if (!xfer_en_n)      ecnt++;
      if (mem_cs) begin
        cs_addr = mem_addr;
        cs_mem  = mem_is_mem;
        cs_we   = mem_we;
      end
      if (!ready_n && prev_r) begin
        if (sbq.size() == 0) begin
          chk(1'b0, "R10 unexpected ready", 32'd1, 32'd0);
        end else begin
          sb_item_t it;
          it = sbq.pop_front();
          chk(ecnt == int'(it.lat), "R6 latency", ecnt, it.lat);
          chk(cs_addr == it.addr, "R5 address", cs_addr, it.addr);
          chk(cs_mem == it.is_mem, "R4 space", cs_mem, it.is_mem);
          chk(cs_we == !it.is_rd, "R4 direction", cs_we, !it.is_rd);
          if (it.is_rd) begin
            chk(rdata_oe && rdata_out == it.data, "R7 read data", rdata_out, it.data);
          end else begin
            chk((it.is_mem ? mem_arr[it.addr[3:0]] : reg_arr[it.addr[3:0]]) == it.data,
                "R7 write stored",
                it.is_mem ? mem_arr[it.addr[3:0]] : reg_arr[it.addr[3:0]], it.data);
            chk(!rdata_oe && rdata_out == '0, "R8 bus idle on write", rdata_out, 0);
          end
        end
      end
      prev_x = xfer_en_n;
      prev_r = ready_n;
    end
  end

  // Driver: queues the expected result, then runs one host cycle.
  task automatic host_xfer(input logic is_mem, input logic is_rd,
                           input logic [AW-1:0] addr, input logic [DW-1:0] wdata,
                           input bit scramble, input bit drive_addr, input int hold);
    sb_item_t it;
    it.is_rd  = is_rd;
    it.is_mem = is_mem;
    it.addr   = addr;
    it.lat    = (is_mem && is_rd) ? 4'd7 : 4'd3;
    if (is_rd) begin
      it.data = is_mem ? exp_mem[addr[3:0]] : exp_reg[addr[3:0]];
    end else begin
      it.data = wdata;
      if (is_mem) exp_mem[addr[3:0]] = wdata;
      else        exp_reg[addr[3:0]] = wdata;
    end
    sbq.push_back(it);

    @(posedge clk); #5;
    space_mem = is_mem;
    dir_rd    = is_rd;
    wdata_in  = wdata;
    if (drive_addr) addr_in = addr;
    select_n  = 1'b0;
    strobe_n  = 1'b0;
    while (xfer_en_n) begin
      @(posedge clk); #5;
    end
    @(posedge clk); #5;
    if (scramble) begin
      space_mem = ~is_mem;
      dir_rd    = ~is_rd;
      wdata_in  = ~wdata;
      if (drive_addr) addr_in = ~addr;
    end
    while (ready_n) begin
      chk(!rdata_oe && rdata_out == '0, "R8 bus idle before ready", rdata_out, 0);
      @(posedge clk); #5;
    end
    for (int h = 0; h < hold; h++) begin
      @(posedge clk); #5;
      chk(!ready_n && !xfer_en_n, "R10 ready held", {ready_n, xfer_en_n}, 0);
    end
    strobe_n = 1'b1;
    select_n = 1'b1;
    @(posedge clk); #5;
    chk(ready_n && xfer_en_n, "R9 release", {ready_n, xfer_en_n}, 2'b11);
    chk(rdata_out == '0, "R8 bus idle after release", rdata_out, 0);
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    report();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem_arr[i] = 16'hA000 + 16'(i);
      reg_arr[i] = 16'hB000 + 16'(i);
      exp_mem[i] = 16'hA000 + 16'(i);
      exp_reg[i] = 16'hB000 + 16'(i);
    end
    rst_n = 1'b0;
    strobe_n = 1'b1; select_n = 1'b1; space_mem = 1'b0; dir_rd = 1'b0;
    addr_lat = 1'b1; addr_in = '0; wdata_in = '0; eng_req = 1'b0;
    repeat (4) @(negedge clk);
    chk(xfer_en_n && ready_n && !mem_cs && rdata_out == '0, "R12 reset state",
        {xfer_en_n, ready_n, mem_cs}, 3'b110);
    @(posedge clk); #5;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #5;
    chk(xfer_en_n && ready_n && !mem_cs && rdata_out == '0, "R12 after reset",
        {xfer_en_n, ready_n, mem_cs}, 3'b110);

    // R1: strobe without select is no request.
    strobe_n = 1'b0;
    select_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(xfer_en_n, "R1 strobe alone", xfer_en_n, 1);
    end
    strobe_n = 1'b1;
    select_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(xfer_en_n, "R1 select alone", xfer_en_n, 1);
    end
    select_n = 1'b1;

    // R6/R7: each access kind.
    host_xfer(1'b1, 1'b0, 16'h0003, 16'h1234, 1'b0, 1'b1, 0);
    host_xfer(1'b0, 1'b0, 16'h0005, 16'h5678, 1'b0, 1'b1, 0);
    host_xfer(1'b1, 1'b1, 16'h0003, 16'h0000, 1'b0, 1'b1, 0);
    host_xfer(1'b0, 1'b1, 16'h0005, 16'h0000, 1'b0, 1'b1, 0);
    host_xfer(1'b1, 1'b1, 16'h0009, 16'h0000, 1'b0, 1'b1, 0);

    // R4/R5: late changes on qualifiers, address and data are ignored.
    host_xfer(1'b1, 1'b1, 16'h0003, 16'h0000, 1'b1, 1'b1, 0);
    host_xfer(1'b0, 1'b0, 16'h0006, 16'h0F0F, 1'b1, 1'b1, 0);
    host_xfer(1'b0, 1'b1, 16'h0006, 16'h0000, 1'b0, 1'b1, 0);

    // R11: address held through a low latch control.
    @(posedge clk); #5;
    addr_lat = 1'b1;
    addr_in  = 16'h000C;
    @(posedge clk); #5;
    addr_lat = 1'b0;
    addr_in  = 16'hFFF1;
    host_xfer(1'b1, 1'b0, 16'h000C, 16'h4242, 1'b0, 1'b0, 0);
    addr_in  = 16'hFFF2;
    host_xfer(1'b1, 1'b1, 16'h000C, 16'h0000, 1'b0, 1'b0, 0);
    addr_lat = 1'b1;

    // R2/R3: engine priority and blocking.
    @(posedge clk); #5;
    eng_req = 1'b1;
    fork
      host_xfer(1'b0, 1'b0, 16'h0002, 16'h9A9A, 1'b0, 1'b1, 0);
      begin
        repeat (4) begin
          @(negedge clk);
          chk(xfer_en_n && eng_gnt, "R2 engine holds storage", {xfer_en_n, eng_gnt}, 2'b11);
        end
        @(posedge clk); #5;
        eng_req = 1'b0;
        @(posedge clk); #5;
        chk(!xfer_en_n, "R2 start after engine", xfer_en_n, 0);
        eng_req = 1'b1;
        #1;
        chk(!eng_gnt, "R3 engine blocked", eng_gnt, 0);
      end
    join
    @(negedge clk);
    chk(eng_gnt, "R3 engine granted when idle", eng_gnt, 1);
    eng_req = 1'b0;

    // R10: strobe held low after ready.
    host_xfer(1'b0, 1'b1, 16'h0005, 16'h0000, 1'b0, 1'b1, 4);

    // Back-to-back cycles.
    for (int i = 0; i < 4; i++) begin
      host_xfer(1'b1, 1'b0, 16'(i), 16'(i * 16'h1111 + 7), 1'b0, 1'b1, 0);
    end
    for (int i = 0; i < 4; i++) begin
      host_xfer(1'b1, 1'b1, 16'(i), 16'h0000, 1'b0, 1'b1, 0);
    end

    repeat (5) @(negedge clk);
    chk(sbq.size() == 0, "R6 all transfers completed", sbq.size(), 0);
    report();
  end

endmodule